// File: doc/BRIEF.md
# Granule free-list manager with release queue

This block keeps the pool of unused storage granules as a singly linked chain inside a small on-chip link memory. Each link memory entry holds a 15-bit pointer to the next granule. The block tracks the live head, the live tail and the number of free granules. Software reaches everything through a byte-wide register port.

Software can start the pool in one of two ways. In the first, it writes the links itself through a memory window, then sets the head and the tail. In the second, it leaves the head and the tail at zero, and the block chains granules 0, 1, 2 and onward by itself, one link per cycle. In both cases the write of the count's upper byte is the step that commits the setup.

A test port lets a client take the head granule or hand back a short chain. Every chain handed back is appended to the pool and also recorded in an 8-entry release queue. Software drains that queue one entry per rising edge of a control bit.

Top module: `gran_free_mgr`

## Requirements
- R1: After reset the free count, head and tail are 0 and busy is low. The control register (address 6) reads 0x02, with bit 1 meaning the release queue is empty. All six info bytes (addresses 7 to 12) read 0.
- R2: The head is at addresses 0 (low byte) and 1 (high byte) and the tail at addresses 2 and 3. Both read back their live values. High-byte bit 7 reads 0 because pointers are 15 bits. The free count reads at addresses 4 and 5.
- R3: Address 13/14 sets a link memory index. Address 15 stages the low data byte and a write to address 16 stores {byte, staged} at that index. Reads of 15 and 16 return the stored entry's low and high bytes.
- R4: Writing address 5 while the head or the tail is nonzero adopts the CPU-built chain unchanged, with count {addr5, addr4}. Busy stays low and allocation follows the link memory.
- R5: Writing address 5 while head and tail are both 0 starts hardware linking for N granules, with N clamped to the link memory depth (64). Granule i gets link i+1 for i < N-1, the head becomes 0, the tail N-1 and the count N. Busy is high for exactly N-1 cycles.
- R6: A hardware-link commit with N = 0 leaves the count at 0 and never raises busy, and allocation is then refused.
- R7: While busy, allocation is refused, releases are ignored (count and queue unchanged) and CPU writes to addresses 0 to 5 and 13 to 16 have no effect.
- R8: With allocReq high, a count above 0, busy low, no accepted release and no commit, allocGrant rises in the same cycle and allocPtr shows the head. At the clock edge the head takes the head's link and the count drops by 1. With a count of 0 there is no grant.
- R9: A release with relCnt ≠ 0 and busy low writes link[tail] = relHead, sets tail = relTail and adds relCnt to the count. It sets head = relHead if the count was 0. A release wins over an allocation in the same cycle. A release with relCnt = 0 is ignored.
- R10: Every accepted release is pushed into the 8-deep release queue. When the queue is full the entry is dropped, the pool is still appended, and control bit 2 (overflow) sets and stays set until reset.
- R11: Only a 0-to-1 change of control bit 0 pops the queue, and only when it is not empty. Rewriting 1 while already 1 pops nothing, and a pop of an empty queue leaves the info bytes unchanged.
- R12: A popped entry is packed LSB-first across info bytes 7 to 10: head in bits 0 to 14, tail in bits 15 to 29 and count in bits 30 to 31. Bytes 11 and 12 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWe | input | 1 | Register write strobe |
| cpuAddr | input | 5 | Register address |
| cpuWdata | input | 8 | Register write data |
| cpuRdata | output | 8 | Register read data (combinational) |
| allocReq | input | 1 | Request to take one free granule |
| allocGrant | output | 1 | Granule taken this cycle |
| allocPtr | output | 15 | Granule handed out |
| relReq | input | 1 | Hand back a chain |
| relHead | input | 15 | First granule of the returned chain |
| relTail | input | 15 | Last granule of the returned chain |
| relCnt | input | 2 | Granules in the returned chain |
| busy | output | 1 | Hardware linking in progress |
| freeCount | output | 16 | Granules in the pool |

## Verification
The list is set up in both modes, and the bench tells them apart by the order of the allocations that follow. A hand-built chain yields non-consecutive pointers (30, 31, 35). A hardware-linked chain yields 0 to N-1 and a busy window of exactly N-1 cycles. A count of 0 and a count above the memory depth probe the edges of the hardware mode. Releases into an empty pool versus a non-empty one show whether the head or the old tail's link is rewritten. A release paired with an allocation shows which one wins. Queue pops with a held control bit, an empty queue and a full queue separate edge detection, empty protection and overflow dropping.

// File: rtl/gfl_pkg.sv
package gfl_pkg;
  localparam logic [4:0] A_HEAD_LO  = 5'd0;
  localparam logic [4:0] A_HEAD_HI  = 5'd1;
  localparam logic [4:0] A_TAIL_LO  = 5'd2;
  localparam logic [4:0] A_TAIL_HI  = 5'd3;
  localparam logic [4:0] A_CNT_LO   = 5'd4;
  localparam logic [4:0] A_CNT_HI   = 5'd5;
  localparam logic [4:0] A_CTRL     = 5'd6;
  localparam logic [4:0] A_INFO0    = 5'd7;
  localparam logic [4:0] A_INFO1    = 5'd8;
  localparam logic [4:0] A_INFO2    = 5'd9;
  localparam logic [4:0] A_INFO3    = 5'd10;
  localparam logic [4:0] A_INFO4    = 5'd11;
  localparam logic [4:0] A_INFO5    = 5'd12;
  localparam logic [4:0] A_LADDR_LO = 5'd13;
  localparam logic [4:0] A_LADDR_HI = 5'd14;
  localparam logic [4:0] A_LDATA_LO = 5'd15;
  localparam logic [4:0] A_LDATA_HI = 5'd16;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic headLoWe;
    logic headHiWe;
    logic tailLoWe;
    logic tailHiWe;
    logic cntLoWe;
    logic adoptCpu;
    logic startHw;
    logic linkAddrLoWe;
    logic linkAddrHiWe;
    logic linkDataLoWe;
    logic linkMemWe;
    logic hwWe;
    logic popReq;
    logic popLevel;
  } gflStrobes_t;
endpackage

// File: rtl/gfl_ctrl.sv
module gfl_ctrl import gfl_pkg::*; #(
  parameter int PTR_W     = 15,
  parameter int CNT_W     = 16,
  parameter int MEM_DEPTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuWe,
  input  logic [4:0]       cpuAddr,
  input  logic [7:0]       cpuWdata,
  input  logic [7:0]       cntLoStage,
  input  logic             headZero,
  input  logic             tailZero,
  output gflStrobes_t      stb,
  output logic [PTR_W-1:0] hwIdx,
  output logic [CNT_W-1:0] hwCnt,
  output logic             busy
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(MEM_DEPTH);

  typedef enum logic {S_IDLE, S_LINK} ctrlState_t;
  ctrlState_t stateQ;
  logic [PTR_W-1:0] idxQ, lastQ;
  logic popBitQ;
  logic [CNT_W-1:0] rawCnt;
  logic wrOk, bothZero;

  assign busy     = (stateQ == S_LINK);
  assign wrOk     = cpuWe && !busy;
  assign bothZero = headZero && tailZero;
  assign rawCnt   = CNT_W'({cpuWdata, cntLoStage});
  assign hwCnt    = (rawCnt > DEPTH_C) ? DEPTH_C : rawCnt;
  assign hwIdx    = idxQ;

  always_comb begin
    stb = '0;
    stb.headLoWe     = wrOk && cpuAddr == A_HEAD_LO;
    stb.headHiWe     = wrOk && cpuAddr == A_HEAD_HI;
    stb.tailLoWe     = wrOk && cpuAddr == A_TAIL_LO;
    stb.tailHiWe     = wrOk && cpuAddr == A_TAIL_HI;
    stb.cntLoWe      = wrOk && cpuAddr == A_CNT_LO;
    stb.adoptCpu     = wrOk && cpuAddr == A_CNT_HI && !bothZero;
    stb.startHw      = wrOk && cpuAddr == A_CNT_HI && bothZero;
    stb.linkAddrLoWe = wrOk && cpuAddr == A_LADDR_LO;
    stb.linkAddrHiWe = wrOk && cpuAddr == A_LADDR_HI;
    stb.linkDataLoWe = wrOk && cpuAddr == A_LDATA_LO;
    stb.linkMemWe    = wrOk && cpuAddr == A_LDATA_HI;
    stb.hwWe         = busy;
    stb.popReq       = cpuWe && cpuAddr == A_CTRL && cpuWdata[0] && !popBitQ;
    stb.popLevel     = popBitQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= S_IDLE;
      idxQ    <= '0;
      lastQ   <= '0;
      popBitQ <= 1'b0;
    end else begin
      if (cpuWe && cpuAddr == A_CTRL) popBitQ <= cpuWdata[0];
      case (stateQ)
        S_IDLE: if (stb.startHw && hwCnt > CNT_W'(1)) begin
          stateQ <= S_LINK;
          idxQ   <= '0;
          lastQ  <= PTR_W'(hwCnt - CNT_W'(2));
        end
        default: begin
          if (idxQ == lastQ) stateQ <= S_IDLE;
          else               idxQ   <= idxQ + PTR_W'(1);
        end
      endcase
    end
  end
endmodule

// File: rtl/gfl_dp.sv
module gfl_dp import gfl_pkg::*; #(
  parameter int PTR_W      = 15,
  parameter int CNT_W      = 16,
  parameter int REL_W      = 2,
  parameter int MEM_DEPTH  = 64,
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  gflStrobes_t      stb,
  input  logic [PTR_W-1:0] hwIdx,
  input  logic [CNT_W-1:0] hwCnt,
  input  logic             busy,
  input  logic [4:0]       cpuAddr,
  input  logic [7:0]       cpuWdata,
  output logic [7:0]       cpuRdata,
  input  logic             allocReq,
  output logic             allocGrant,
  output logic [PTR_W-1:0] allocPtr,
  input  logic             relReq,
  input  logic [PTR_W-1:0] relHead,
  input  logic [PTR_W-1:0] relTail,
  input  logic [REL_W-1:0] relCnt,
  output logic [CNT_W-1:0] freeCount,
  output logic             headZero,
  output logic             tailZero,
  output logic [7:0]       cntLoStage
);
  localparam int IDX_W  = $clog2(MEM_DEPTH);
  localparam int FA_W   = $clog2(FIFO_DEPTH);
  localparam int ENT_W  = 2 * PTR_W + REL_W;
  localparam int HI_W   = PTR_W - 8;
  localparam int INFO_W = 48;

  logic [PTR_W-1:0] headQ, tailQ, linkAddrQ;
  logic [CNT_W-1:0] cntQ;
  logic [7:0]       cntLoQ, dataLoQ;
  logic [PTR_W-1:0] linkMem [MEM_DEPTH];
  logic [ENT_W-1:0] fifoMem [FIFO_DEPTH];
  logic [FA_W:0]    wrQ, rdQ;
  logic [ENT_W-1:0] infoQ;
  logic             ovfQ;
  logic             relAcc, commit, fifoEmpty, fifoFull;
  logic [INFO_W-1:0] infoPad;
  logic [PTR_W-1:0] linkView;

  assign relAcc     = relReq && !busy && relCnt != '0;
  assign commit     = stb.adoptCpu || stb.startHw;
  assign allocGrant = allocReq && !busy && cntQ != '0 && !relAcc && !commit;
  assign allocPtr   = headQ;
  assign freeCount  = cntQ;
  assign headZero   = headQ == '0;
  assign tailZero   = tailQ == '0;
  assign cntLoStage = cntLoQ;
  assign fifoEmpty  = wrQ == rdQ;
  assign fifoFull   = (wrQ[FA_W] != rdQ[FA_W]) && (wrQ[FA_W-1:0] == rdQ[FA_W-1:0]);
  assign infoPad    = INFO_W'(infoQ);
  assign linkView   = linkMem[linkAddrQ[IDX_W-1:0]];

  // list state: commit, then CPU bytes, then release or allocation
  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ <= '0; tailQ <= '0; cntQ <= '0;
      cntLoQ <= '0; dataLoQ <= '0; linkAddrQ <= '0;
    end else begin
      if (stb.cntLoWe)      cntLoQ  <= cpuWdata;
      if (stb.linkDataLoWe) dataLoQ <= cpuWdata;
      if (stb.linkAddrLoWe) linkAddrQ[7:0] <= cpuWdata;
      if (stb.linkAddrHiWe) linkAddrQ[PTR_W-1:8] <= cpuWdata[HI_W-1:0];
      if (stb.startHw) begin
        headQ <= '0;
        tailQ <= (hwCnt == '0) ? '0 : PTR_W'(hwCnt - CNT_W'(1));
        cntQ  <= hwCnt;
      end else if (stb.adoptCpu) begin
        cntQ <= CNT_W'({cpuWdata, cntLoQ});
      end else begin
        if (stb.headLoWe) headQ[7:0]       <= cpuWdata;
        if (stb.headHiWe) headQ[PTR_W-1:8] <= cpuWdata[HI_W-1:0];
        if (stb.tailLoWe) tailQ[7:0]       <= cpuWdata;
        if (stb.tailHiWe) tailQ[PTR_W-1:8] <= cpuWdata[HI_W-1:0];
        if (relAcc) begin
          tailQ <= relTail;
          cntQ  <= cntQ + CNT_W'(relCnt);
          if (cntQ == '0) headQ <= relHead;
        end else if (allocGrant) begin
          headQ <= linkMem[headQ[IDX_W-1:0]];
          cntQ  <= cntQ - CNT_W'(1);
        end
      end
    end
  end

  // link memory, no reset
  always_ff @(posedge clk) begin
    if (stb.hwWe)      linkMem[hwIdx[IDX_W-1:0]] <= hwIdx + PTR_W'(1);
    if (stb.linkMemWe) linkMem[linkAddrQ[IDX_W-1:0]] <= PTR_W'({cpuWdata, dataLoQ});
    if (relAcc && cntQ != '0 && !commit) linkMem[tailQ[IDX_W-1:0]] <= relHead;
  end

  // release queue
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrQ <= '0; rdQ <= '0; infoQ <= '0; ovfQ <= 1'b0;
    end else begin
      if (relAcc) begin
        if (fifoFull) ovfQ <= 1'b1;
        else begin
          fifoMem[wrQ[FA_W-1:0]] <= {relCnt, relTail, relHead};
          wrQ <= wrQ + (FA_W+1)'(1);
        end
      end
      if (stb.popReq && !fifoEmpty) begin
        infoQ <= fifoMem[rdQ[FA_W-1:0]];
        rdQ   <= rdQ + (FA_W+1)'(1);
      end
    end
  end

  always_comb begin
    case (cpuAddr)
      A_HEAD_LO:  cpuRdata = headQ[7:0];
      A_HEAD_HI:  cpuRdata = 8'(headQ[PTR_W-1:8]);
      A_TAIL_LO:  cpuRdata = tailQ[7:0];
      A_TAIL_HI:  cpuRdata = 8'(tailQ[PTR_W-1:8]);
      A_CNT_LO:   cpuRdata = cntQ[7:0];
      A_CNT_HI:   cpuRdata = 8'(cntQ[CNT_W-1:8]);
      A_CTRL:     cpuRdata = {5'b0, ovfQ, fifoEmpty, stb.popLevel};
      A_INFO0:    cpuRdata = infoPad[7:0];
      A_INFO1:    cpuRdata = infoPad[15:8];
      A_INFO2:    cpuRdata = infoPad[23:16];
      A_INFO3:    cpuRdata = infoPad[31:24];
      A_INFO4:    cpuRdata = infoPad[39:32];
      A_INFO5:    cpuRdata = infoPad[47:40];
      A_LADDR_LO: cpuRdata = linkAddrQ[7:0];
      A_LADDR_HI: cpuRdata = 8'(linkAddrQ[PTR_W-1:8]);
      A_LDATA_LO: cpuRdata = linkView[7:0];
      A_LDATA_HI: cpuRdata = 8'(linkView[PTR_W-1:8]);
      default:    cpuRdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/gran_free_mgr.sv
module gran_free_mgr import gfl_pkg::*; #(
  parameter int PTR_W      = 15,
  parameter int CNT_W      = 16,
  parameter int REL_W      = 2,
  parameter int MEM_DEPTH  = 64,
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuWe,
  input  logic [4:0]       cpuAddr,
  input  logic [7:0]       cpuWdata,
  output logic [7:0]       cpuRdata,
  input  logic             allocReq,
  output logic             allocGrant,
  output logic [PTR_W-1:0] allocPtr,
  input  logic             relReq,
  input  logic [PTR_W-1:0] relHead,
  input  logic [PTR_W-1:0] relTail,
  input  logic [REL_W-1:0] relCnt,
  output logic             busy,
  output logic [CNT_W-1:0] freeCount
);
  gflStrobes_t      stb;
  logic [PTR_W-1:0] hwIdx;
  logic [CNT_W-1:0] hwCnt;
  logic             headZero, tailZero;
  logic [7:0]       cntLoStage;

  gfl_ctrl #(.PTR_W(PTR_W), .CNT_W(CNT_W), .MEM_DEPTH(MEM_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cntLoStage(cntLoStage), .headZero(headZero), .tailZero(tailZero),
    .stb(stb), .hwIdx(hwIdx), .hwCnt(hwCnt), .busy(busy)
  );

  gfl_dp #(.PTR_W(PTR_W), .CNT_W(CNT_W), .REL_W(REL_W), .MEM_DEPTH(MEM_DEPTH),
           .FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .hwIdx(hwIdx), .hwCnt(hwCnt), .busy(busy),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .allocReq(allocReq), .allocGrant(allocGrant), .allocPtr(allocPtr),
    .relReq(relReq), .relHead(relHead), .relTail(relTail), .relCnt(relCnt),
    .freeCount(freeCount), .headZero(headZero), .tailZero(tailZero),
    .cntLoStage(cntLoStage)
  );
endmodule

// File: rtl/gfl_chk.sv
module gfl_chk #(
  parameter int CNT_W = 16,
  parameter int REL_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             cpuWe,
  input logic [4:0]       cpuAddr,
  input logic             allocGrant,
  input logic             relReq,
  input logic [REL_W-1:0] relCnt,
  input logic             busy,
  input logic [CNT_W-1:0] freeCount
);
  // R7
  busy_no_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !allocGrant);

  // R8
  alloc_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    allocGrant |=> freeCount == $past(freeCount) - CNT_W'(1));

  // R8
  alloc_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (freeCount == '0) |-> !allocGrant);

  // R9
  rel_add_chk: assert property (@(posedge clk) disable iff (!rstN)
    (relReq && !busy && relCnt != '0 && !(cpuWe && cpuAddr == 5'd5))
      |=> freeCount == $past(freeCount) + CNT_W'($past(relCnt)));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(freeCount));
endmodule

bind gran_free_mgr gfl_chk u_gfl_chk (.*);

// File: tb/test_gran_free_mgr.sv
`timescale 1ns/1ps
module test_gran_free_mgr;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuWe = 1'b0;
  logic [4:0] cpuAddr = '0;
  logic [7:0] cpuWdata = '0;
  logic [7:0] cpuRdata;
  logic allocReq = 1'b0;
  logic allocGrant;
  logic [14:0] allocPtr;
  logic relReq = 1'b0;
  logic [14:0] relHead = '0, relTail = '0;
  logic [1:0] relCnt = '0;
  logic busy;
  logic [15:0] freeCount;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  gran_free_mgr i_gran_free_mgr (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cpuWe = 1'b1; cpuAddr = 5'(a); cpuWdata = 8'(d);
    @(negedge clk);
    cpuWe = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    cpuAddr = 5'(a);
    #1 d = int'(cpuRdata);
  endtask

  task automatic chkRd(input int a, input int exp, input string req);
    int d;
    rd(a, d);
    check(d == exp, req, d, exp);
  endtask

  task automatic alloc(output bit g, output int p);
    @(negedge clk);
    allocReq = 1'b1;
    #1 g = allocGrant; p = int'(allocPtr);
    @(negedge clk);
    allocReq = 1'b0;
  endtask

  task automatic release_chain(input int h, input int t, input int c, input bit withAlloc, output bit g);
    @(negedge clk);
    relReq = 1'b1; relHead = 15'(h); relTail = 15'(t); relCnt = 2'(c);
    allocReq = withAlloc;
    #1 g = allocGrant;
    @(negedge clk);
    relReq = 1'b0; allocReq = 1'b0;
  endtask

  task automatic setLink(input int idx, input int val);
    wr(13, idx & 8'hFF); wr(14, idx >> 8);
    wr(15, val & 8'hFF); wr(16, val >> 8);
  endtask

  task automatic expectAllocs(input int n, input int first, input int step, input string req);
    bit g; int p;
    for (int i = 0; i < n; i++) begin
      alloc(g, p);
      check(g == 1'b1, req, g, 1);
      check(p == first + i * step, req, p, first + i * step);
    end
  endtask

  task automatic pop();
    wr(6, 0); wr(6, 1);
  endtask

  task automatic chkInfo(input int h, input int t, input int c, input string req);
    int w, d;
    w = (c << 30) | (t << 15) | h;
    for (int k = 0; k < 4; k++) begin
      rd(7 + k, d);
      check(d == ((w >> (8 * k)) & 8'hFF), req, d, (w >> (8 * k)) & 8'hFF);
    end
    chkRd(11, 0, req);
    chkRd(12, 0, req);
  endtask

  task automatic t_reset();
    check(freeCount == 0, "R1 count", freeCount, 0);
    check(busy == 1'b0, "R1 busy", busy, 0);
    for (int a = 0; a < 6; a++) chkRd(a, 0, "R1 list regs");
    chkRd(6, 2, "R1 ctrl");
    for (int a = 7; a < 13; a++) chkRd(a, 0, "R1 info");
  endtask

  task automatic t_regs();
    wr(0, 8'hFF); wr(1, 8'hFF);
    chkRd(0, 8'hFF, "R2 head lo");
    chkRd(1, 8'h7F, "R2 head hi");
    wr(2, 8'h34); wr(3, 8'h12);
    chkRd(2, 8'h34, "R2 tail lo");
    chkRd(3, 8'h12, "R2 tail hi");
    wr(0, 0); wr(1, 0); wr(2, 0); wr(3, 0);
    chkRd(1, 0, "R2 head cleared");
  endtask

  task automatic t_linkmem();
    setLink(5, 16'h5CAB);
    chkRd(13, 5, "R3 index");
    chkRd(15, 8'hAB, "R3 data lo");
    chkRd(16, 8'h5C, "R3 data hi");
    wr(15, 8'h01); wr(16, 8'hFF);
    chkRd(16, 8'h7F, "R3 15-bit store");
  endtask

  task automatic t_zero();
    bit g; int p;
    wr(4, 0); wr(5, 0);
    check(busy == 1'b0, "R6 no busy", busy, 0);
    check(freeCount == 0, "R6 count", freeCount, 0);
    alloc(g, p);
    check(g == 1'b0, "R6 refused", g, 0);
  endtask

  task automatic t_hwlink();
    int n; bit g; int p;
    wr(4, 5); wr(5, 0);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    check(n == 4, "R5 busy cycles", n, 4);
    check(freeCount == 5, "R5 count", freeCount, 5);
    chkRd(2, 4, "R5 tail");
    for (int i = 0; i < 4; i++) begin
      wr(13, i);
      chkRd(15, i + 1, "R5 link");
    end
    expectAllocs(5, 0, 1, "R5 order");
    alloc(g, p);
    check(g == 1'b0, "R8 empty refused", g, 0);
    check(freeCount == 0, "R8 count", freeCount, 0);
  endtask

  task automatic t_release();
    bit g;
    setLink(10, 11);
    release_chain(10, 11, 2, 0, g);
    check(freeCount == 2, "R9 count", freeCount, 2);
    chkRd(0, 10, "R9 head from empty");
    chkRd(2, 11, "R9 tail");
    release_chain(20, 20, 1, 0, g);
    check(freeCount == 3, "R9 append", freeCount, 3);
    release_chain(25, 25, 0, 0, g);
    check(freeCount == 3, "R9 zero ignored", freeCount, 3);
    chkRd(2, 20, "R9 zero keeps tail");
    release_chain(21, 21, 1, 1, g);
    check(g == 1'b0, "R9 release wins", g, 0);
    check(freeCount == 4, "R9 count after tie", freeCount, 4);
    expectAllocs(2, 10, 1, "R9 chain");
    expectAllocs(2, 20, 1, "R9 appended");
  endtask

  task automatic t_pop();
    chkRd(6, 0, "R10 not empty");
    pop();
    chkInfo(10, 11, 2, "R12 entry1");
    wr(6, 1);
    chkInfo(10, 11, 2, "R11 held bit");
    pop();
    chkInfo(20, 20, 1, "R11 entry2");
    pop();
    chkInfo(21, 21, 1, "R11 entry3");
    chkRd(6, 3, "R11 empty");
    pop();
    chkInfo(21, 21, 1, "R11 empty pop");
  endtask

  task automatic t_cpubuilt();
    wr(6, 0);
    setLink(30, 31);
    setLink(31, 35);
    wr(0, 30); wr(1, 0); wr(2, 35); wr(3, 0);
    wr(4, 3); wr(5, 0);
    check(busy == 1'b0, "R4 no busy", busy, 0);
    check(freeCount == 3, "R4 count", freeCount, 3);
    expectAllocs(2, 30, 1, "R4 chain");
    expectAllocs(1, 35, 0, "R4 chain end");
  endtask

  task automatic t_busy();
    bit g; int p; int n;
    wr(0, 0); wr(1, 0); wr(2, 0); wr(3, 0);
    wr(4, 100); wr(5, 0);
    check(busy == 1'b1, "R5 busy", busy, 1);
    alloc(g, p);
    check(g == 1'b0, "R7 alloc refused", g, 0);
    release_chain(50, 50, 1, 0, g);
    wr(0, 8'h55);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    check(freeCount == 64, "R5 clamp count", freeCount, 64);
    chkRd(0, 0, "R7 head write ignored");
    chkRd(2, 63, "R5 clamp tail");
    chkRd(6, 2, "R7 release ignored");
    wr(13, 62);
    chkRd(15, 63, "R5 last link");
  endtask

  task automatic t_overflow();
    bit g;
    for (int i = 0; i < 9; i++) release_chain(40 + i, 40 + i, 1, 0, g);
    check(freeCount == 73, "R10 pool still appended", freeCount, 73);
    chkRd(6, 4, "R10 overflow set");
    for (int i = 0; i < 8; i++) pop();
    chkInfo(47, 47, 1, "R10 ninth dropped");
    chkRd(6, 8'h07, "R10 empty sticky");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_linkmem();
    t_zero();
    t_hwlink();
    t_release();
    t_pop();
    t_cpubuilt();
    t_busy();
    t_overflow();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule